// File: doc/BRIEF.md
# Video Sync Format Detector

This block classifies an incoming video sync stream as standard, enhanced or high definition. It also drives an active-low high-definition flag, which is meant to switch off an external standard-definition chroma filter. Two sliced comparator outputs feed it. One is high while the input is below the sync-tip slice level, and it marks the negative sync half. The other pulses high on a positive tri-level excursion. The block times the interval between successive negative sync edges and sorts each interval into a line-rate band. A new band is adopted only after it has been seen on several lines in a row. On the same edges the block checks whether each line carries a positive excursion right after the negative half.

A separate vertical detector supplies a field pulse and a bit that says whether the field began mid-line. From these the block derives a lock indication and an interlaced/progressive decision. The high-definition flag is updated only at a field pulse, so it follows a new input after a one-to-two-field qualification delay. When sync edges stop, the block falls back to its idle state on its own. When sync returns, it detects the format again without any reset.

Top module: `vid_fmt_detect`

## Requirements
- R1: After reset fmt_code_o is 0 (no format), locked_o is 0, interlaced_o is 0 and hd_flag_n_o is 1.
- R2: The period is the number of clock cycles between two consecutive rising edges of sync_tip_i. A period P with SD_MIN_CYC <= P <= LINE_MAX_CYC is class 1 (standard). A period with ED_MIN_CYC <= P < SD_MIN_CYC is class 2 (enhanced). A period with HD_MIN_CYC <= P < ED_MIN_CYC is class 3 (high definition). fmt_code_o reports the adopted class.
- R3: A class different from the adopted one is adopted only after CONFIRM_LINES consecutive periods of that class. A shorter run, ended by a period of the adopted class, leaves fmt_code_o unchanged.
- R4: A period shorter than HD_MIN_CYC, or longer than LINE_MAX_CYC but below the loss limit, casts no vote and leaves fmt_code_o and locked_o unchanged.
- R5: A line counts as tri-level when pos_exc_i is high in the cycle sync_tip_i falls or within TRI_WIN_CYC cycles after it. Tri-level state is set after TRI_LINES consecutive tri-level lines and cleared after TRI_LINES consecutive lines without one. Each line is judged at the next rising edge of sync_tip_i.
- R6: locked_o rises at a rising edge of vsync_i while fmt_code_o is nonzero. It drops when the adopted class changes or when sync is lost.
- R7: hd_flag_n_o goes low only at a rising edge of vsync_i, and only when the class is 3 and tri-level state is set. Between vertical pulses it holds its value, and it is high whenever locked_o is 0.
- R8: Bi-level sync at the high-definition rate, and tri-level sync at the standard or enhanced rate, keep hd_flag_n_o high.
- R9: At each rising edge of vsync_i while locked, field_half_i is compared with its value at the previous locked vertical pulse. interlaced_o is 1 if they differ and 0 if they match. The first pulse after locking gives 0, and interlaced_o is 0 while unlocked.
- R10: If no rising edge of sync_tip_i arrives for 2*LINE_MAX_CYC cycles, fmt_code_o returns to 0, locked_o to 0 and hd_flag_n_o to 1, and tri-level state clears. Sync edges that arrive afterwards are detected again with no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_tip_i | input | 1 | High while input is below sync-tip slice level |
| pos_exc_i | input | 1 | High during a positive tri-level excursion |
| vsync_i | input | 1 | Field pulse from the vertical detector |
| field_half_i | input | 1 | Field started mid-line, valid with vsync_i |
| fmt_code_o | output | 2 | Adopted class: 0 none, 1 SD, 2 ED, 3 HD |
| locked_o | output | 1 | Format locked |
| interlaced_o | output | 1 | Interlaced field structure detected |
| hd_flag_n_o | output | 1 | Active-low high-definition tri-level flag |

## Verification
The bench builds the block with SD_MIN_CYC 60, ED_MIN_CYC 30, HD_MIN_CYC 12, LINE_MAX_CYC 100, CONFIRM_LINES 4, TRI_LINES 3 and TRI_WIN_CYC 4. With these values a line lasts only tens of cycles. The bench can then step one line short of and exactly onto the class-confirmation and tri-level counts, place an excursion just outside the window, and cross the 200-cycle loss limit. Each such boundary is reached within a few hundred cycles.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    typedef enum logic [1:0] {
        FMT_NONE = 2'd0,
        FMT_SD   = 2'd1,
        FMT_ED   = 2'd2,
        FMT_HD   = 2'd3
    } vid_fmt_e;

endpackage

// File: rtl/vfd_line_meter.sv
module vfd_line_meter
    import vfd_pkg::*;
#(
    parameter int SD_MIN_CYC    = 1620,
    parameter int ED_MIN_CYC    = 810,
    parameter int HD_MIN_CYC    = 270,
    parameter int LINE_MAX_CYC  = 1890,
    parameter int CONFIRM_LINES = 24
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sync_tip_i,
    output logic     lead_o,
    output logic     trail_o,
    output logic     lost_o,
    output vid_fmt_e fmt_o
);

    localparam int LOSS_CYC = 2 * LINE_MAX_CYC;
    localparam int CNT_W    = $clog2(LOSS_CYC + 1);
    localparam int RUN_W    = $clog2(CONFIRM_LINES + 1);

    localparam logic [CNT_W-1:0] LOSS_C  = CNT_W'(LOSS_CYC);
    localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(LINE_MAX_CYC);
    localparam logic [CNT_W-1:0] SD_C    = CNT_W'(SD_MIN_CYC);
    localparam logic [CNT_W-1:0] ED_C    = CNT_W'(ED_MIN_CYC);
    localparam logic [CNT_W-1:0] HD_C    = CNT_W'(HD_MIN_CYC);
    localparam logic [RUN_W-1:0] CONF_C  = RUN_W'(CONFIRM_LINES);

    typedef struct packed {
        logic             tip;
        logic             seen;
        logic [CNT_W-1:0] cnt;
        vid_fmt_e         cur;
        vid_fmt_e         cand;
        logic [RUN_W-1:0] run;
    } meter_t;

    meter_t q, d;
    logic             lead, trail, lost;
    logic             vote;
    vid_fmt_e         cls;
    logic [RUN_W-1:0] nrun;

    // classify the finished period held in the counter
    always_comb begin
        vote = 1'b1;
        cls  = FMT_NONE;
        if (q.cnt > MAX_C) begin
            vote = 1'b0;
        end else if (q.cnt >= SD_C) begin
            cls = FMT_SD;
        end else if (q.cnt >= ED_C) begin
            cls = FMT_ED;
        end else if (q.cnt >= HD_C) begin
            cls = FMT_HD;
        end else begin
            vote = 1'b0;
        end
    end

    always_comb begin
        lead  = sync_tip_i & ~q.tip;
        trail = ~sync_tip_i & q.tip;
        lost  = ~lead & (q.cnt == LOSS_C - CNT_W'(1));
        nrun  = (cls == q.cand) ? q.run + RUN_W'(1) : RUN_W'(1);

        d     = q;
        d.tip = sync_tip_i;

        if (lead) begin
            d.cnt  = CNT_W'(1);
            d.seen = 1'b1;
            if (q.seen && vote) begin
                if (cls == q.cur) begin
                    d.run = '0;
                end else if (nrun >= CONF_C) begin
                    d.cur = cls;
                    d.run = '0;
                end else begin
                    d.cand = cls;
                    d.run  = nrun;
                end
            end
        end else if (q.cnt != LOSS_C) begin
            d.cnt = q.cnt + CNT_W'(1);
        end

        if (lost) begin
            d.seen = 1'b0;
            d.cur  = FMT_NONE;
            d.cand = FMT_NONE;
            d.run  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{tip: 1'b0, seen: 1'b0, cnt: '0, cur: FMT_NONE,
                   cand: FMT_NONE, run: '0};
        end else begin
            q <= d;
        end
    end

    assign lead_o  = lead;
    assign trail_o = trail;
    assign lost_o  = lost;
    assign fmt_o   = q.cur;

    p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LOSS_C);
    p_loss_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> (q.cur == FMT_NONE));
    p_class_at_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.cur) |-> $past(lead | lost));
    p_run_below_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.run < CONF_C);

endmodule

// File: rtl/vfd_trilevel.sv
module vfd_trilevel #(
    parameter int TRI_LINES   = 8,
    parameter int TRI_WIN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_exc_i,
    input  logic lead_i,
    input  logic trail_i,
    input  logic lost_i,
    output logic tri_o
);

    localparam int RUN_W = $clog2(TRI_LINES + 1);
    localparam int WIN_W = $clog2(TRI_WIN_CYC + 1);

    localparam logic [RUN_W-1:0] LINES_C = RUN_W'(TRI_LINES);
    localparam logic [WIN_W-1:0] WIN_C   = WIN_W'(TRI_WIN_CYC);

    typedef struct packed {
        logic             hit;
        logic [WIN_W-1:0] win;
        logic [RUN_W-1:0] trun;
        logic [RUN_W-1:0] nrun;
        logic             tri_lvl;
    } tri_t;

    tri_t q, d;
    logic in_win;

    always_comb begin
        in_win = trail_i | (q.win != '0);
        d      = q;

        if (trail_i) begin
            d.win = WIN_C;
        end else if (q.win != '0) begin
            d.win = q.win - WIN_W'(1);
        end
        d.hit = q.hit | (pos_exc_i & in_win);

        if (lead_i) begin
            d.hit = 1'b0;
            d.win = '0;
            if (q.hit) begin
                d.nrun = '0;
                if (q.trun < LINES_C) begin
                    d.trun = q.trun + RUN_W'(1);
                end
                if (q.trun + RUN_W'(1) >= LINES_C) begin
                    d.tri_lvl = 1'b1;
                end
            end else begin
                d.trun = '0;
                if (q.nrun < LINES_C) begin
                    d.nrun = q.nrun + RUN_W'(1);
                end
                if (q.nrun + RUN_W'(1) >= LINES_C) begin
                    d.tri_lvl = 1'b0;
                end
            end
        end

        if (lost_i) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tri_o = q.tri_lvl;

    p_tri_set_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tri_lvl) |-> $past(lead_i));
    p_tri_clear_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.tri_lvl) |-> $past(lead_i | lost_i));
    p_runs_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.trun <= LINES_C) && (q.nrun <= LINES_C));

endmodule

// File: rtl/vfd_field_track.sv
module vfd_field_track
    import vfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     vsync_i,
    input  logic     field_half_i,
    input  vid_fmt_e fmt_i,
    input  logic     tri_i,
    input  logic     lost_i,
    output logic     locked_o,
    output logic     hd_n_o,
    output logic     ilace_o
);

    typedef struct packed {
        logic     vs;
        vid_fmt_e fmt_prev;
        logic     locked;
        logic     hd_n;
        logic     ilace;
        logic     have_prev;
        logic     prev_half;
    } trk_t;

    trk_t q, d;
    logic vs_rise, fmt_chg;

    always_comb begin
        vs_rise    = vsync_i & ~q.vs;
        fmt_chg    = (fmt_i != q.fmt_prev);
        d          = q;
        d.vs       = vsync_i;
        d.fmt_prev = fmt_i;

        if (lost_i || fmt_chg) begin
            d.locked    = 1'b0;
            d.hd_n      = 1'b1;
            d.ilace     = 1'b0;
            d.have_prev = 1'b0;
        end else if (vs_rise && (fmt_i != FMT_NONE)) begin
            d.locked    = 1'b1;
            d.hd_n      = ~((fmt_i == FMT_HD) & tri_i);
            d.ilace     = q.have_prev & (field_half_i != q.prev_half);
            d.have_prev = 1'b1;
            d.prev_half = field_half_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{vs: 1'b0, fmt_prev: FMT_NONE, locked: 1'b0, hd_n: 1'b1,
                   ilace: 1'b0, have_prev: 1'b0, prev_half: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign locked_o = q.locked;
    assign hd_n_o   = q.hd_n;
    assign ilace_o  = q.ilace;

    p_hd_low_at_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.hd_n) |-> $past(vs_rise));
    p_hd_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !q.hd_n |-> q.locked);
    p_lock_at_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.locked) |-> $past(vs_rise));
    p_ilace_needs_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.ilace |-> q.locked);

endmodule

// File: rtl/vid_fmt_detect.sv
module vid_fmt_detect
    import vfd_pkg::*;
#(
    parameter int SD_MIN_CYC    = 1620,
    parameter int ED_MIN_CYC    = 810,
    parameter int HD_MIN_CYC    = 270,
    parameter int LINE_MAX_CYC  = 1890,
    parameter int CONFIRM_LINES = 24,
    parameter int TRI_LINES     = 8,
    parameter int TRI_WIN_CYC   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_tip_i,
    input  logic       pos_exc_i,
    input  logic       vsync_i,
    input  logic       field_half_i,
    output logic [1:0] fmt_code_o,
    output logic       locked_o,
    output logic       interlaced_o,
    output logic       hd_flag_n_o
);

    logic     lead_w, trail_w, lost_w, tri_w;
    vid_fmt_e fmt_w;

    vfd_line_meter #(
        .SD_MIN_CYC   (SD_MIN_CYC),
        .ED_MIN_CYC   (ED_MIN_CYC),
        .HD_MIN_CYC   (HD_MIN_CYC),
        .LINE_MAX_CYC (LINE_MAX_CYC),
        .CONFIRM_LINES(CONFIRM_LINES)
    ) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_tip_i(sync_tip_i),
        .lead_o    (lead_w),
        .trail_o   (trail_w),
        .lost_o    (lost_w),
        .fmt_o     (fmt_w)
    );

    vfd_trilevel #(
        .TRI_LINES  (TRI_LINES),
        .TRI_WIN_CYC(TRI_WIN_CYC)
    ) u_tri (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_exc_i(pos_exc_i),
        .lead_i   (lead_w),
        .trail_i  (trail_w),
        .lost_i   (lost_w),
        .tri_o    (tri_w)
    );

    vfd_field_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync_i     (vsync_i),
        .field_half_i(field_half_i),
        .fmt_i       (fmt_w),
        .tri_i       (tri_w),
        .lost_i      (lost_w),
        .locked_o    (locked_o),
        .hd_n_o      (hd_flag_n_o),
        .ilace_o     (interlaced_o)
    );

    assign fmt_code_o = fmt_w;

endmodule

// File: tb/vid_fmt_detect_bench.sv
module vid_fmt_detect_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_tip = 1'b0;
    logic       pos_exc = 1'b0;
    logic       vsync = 1'b0;
    logic       field_half = 1'b0;
    logic [1:0] fmt_code;
    logic       locked, interlaced, hd_n;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    vid_fmt_detect #(
        .SD_MIN_CYC   (60),
        .ED_MIN_CYC   (30),
        .HD_MIN_CYC   (12),
        .LINE_MAX_CYC (100),
        .CONFIRM_LINES(4),
        .TRI_LINES    (3),
        .TRI_WIN_CYC  (4)
    ) u_vid_fmt_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_tip_i  (sync_tip),
        .pos_exc_i   (pos_exc),
        .vsync_i     (vsync),
        .field_half_i(field_half),
        .fmt_code_o  (fmt_code),
        .locked_o    (locked),
        .interlaced_o(interlaced),
        .hd_flag_n_o (hd_n)
    );

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one line: tip high for w cycles, optional excursion d cycles after its fall
    task automatic send_line(input int p, input int w, input bit tri_on, input int dly);
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            sync_tip = (i < w);
            pos_exc  = tri_on && (i >= w + dly) && (i < w + dly + 2);
        end
    endtask

    task automatic lines(input int n, input int p, input int w, input bit tri_on, input int dly);
        for (int k = 0; k < n; k++) send_line(p, w, tri_on, dly);
    endtask

    task automatic vpulse(input bit half);
        @(negedge clk);
        sync_tip = 1'b0; pos_exc = 1'b0;
        vsync = 1'b1; field_half = half;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sync_tip = 1'b0; pos_exc = 1'b0;
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        check("R1 fmt", int'(fmt_code), 0);
        check("R1 locked", int'(locked), 0);
        check("R1 interlaced", int'(interlaced), 0);
        check("R1 hd_n", int'(hd_n), 1);
    endtask

    task automatic t_sd_acquire();
        lines(4, 80, 6, 1'b0, 0);
        check("R3 three votes not enough", int'(fmt_code), 0);
        lines(1, 80, 6, 1'b0, 0);
        check("R2 SD class", int'(fmt_code), 1);
        check("R6 no lock before field", int'(locked), 0);
        vpulse(1'b0);
        check("R6 lock at field", int'(locked), 1);
        check("R8 bi-level SD flag high", int'(hd_n), 1);
        check("R9 first field progressive", int'(interlaced), 0);
    endtask

    task automatic t_votes();
        lines(3, 40, 6, 1'b0, 0);
        lines(2, 80, 6, 1'b0, 0);
        check("R3 short ED run ignored", int'(fmt_code), 1);
        check("R3 lock kept", int'(locked), 1);
        send_line(5, 2, 1'b0, 0);
        send_line(80, 6, 1'b0, 0);
        send_line(150, 6, 1'b0, 0);
        send_line(80, 6, 1'b0, 0);
        check("R4 short/long periods no vote", int'(fmt_code), 1);
        check("R4 lock kept", int'(locked), 1);
    endtask

    task automatic t_interlace();
        vpulse(1'b1);
        check("R9 parity differs", int'(interlaced), 1);
        send_line(80, 6, 1'b0, 0);
        vpulse(1'b1);
        check("R9 parity same", int'(interlaced), 0);
        send_line(80, 6, 1'b0, 0);
        vpulse(1'b0);
        check("R9 parity differs again", int'(interlaced), 1);
    endtask

    task automatic t_hd_tri();
        lines(6, 20, 3, 1'b1, 0);
        check("R2 HD class", int'(fmt_code), 3);
        check("R6 lock drops on change", int'(locked), 0);
        check("R7 flag high while unlocked", int'(hd_n), 1);
        check("R9 cleared while unlocked", int'(interlaced), 0);
        vpulse(1'b0);
        check("R6 relock", int'(locked), 1);
        check("R7 flag low at field", int'(hd_n), 0);
    endtask

    task automatic t_hd_bilevel();
        lines(4, 20, 3, 1'b0, 0);
        check("R7 flag held between fields", int'(hd_n), 0);
        vpulse(1'b0);
        check("R8 bi-level HD rate flag high", int'(hd_n), 1);
        check("R8 class still HD", int'(fmt_code), 3);
    endtask

    task automatic t_tri_count();
        lines(2, 20, 3, 1'b1, 0);
        lines(2, 20, 3, 1'b0, 0);
        vpulse(1'b0);
        check("R5 two tri lines not enough", int'(hd_n), 1);
        lines(4, 20, 3, 1'b1, 8);
        lines(1, 20, 3, 1'b0, 0);
        vpulse(1'b0);
        check("R5 late excursion ignored", int'(hd_n), 1);
        lines(3, 20, 3, 1'b1, 0);
        lines(1, 20, 3, 1'b0, 0);
        vpulse(1'b0);
        check("R5 three tri lines set", int'(hd_n), 0);
    endtask

    task automatic t_ed_tri();
        lines(6, 40, 4, 1'b1, 0);
        check("R2 ED class", int'(fmt_code), 2);
        vpulse(1'b0);
        check("R6 relock ED", int'(locked), 1);
        check("R8 tri-level ED flag high", int'(hd_n), 1);
    endtask

    task automatic t_loss();
        idle(120);
        check("R10 lock held below limit", int'(locked), 1);
        idle(100);
        check("R10 fmt none after loss", int'(fmt_code), 0);
        check("R10 unlocked after loss", int'(locked), 0);
        check("R10 flag high after loss", int'(hd_n), 1);
        lines(6, 20, 3, 1'b1, 0);
        check("R10 redetect HD", int'(fmt_code), 3);
        vpulse(1'b0);
        check("R10 relock after loss", int'(locked), 1);
        check("R10 flag low after redetect", int'(hd_n), 0);
    endtask

    initial begin
        t_reset();
        t_sd_acquire();
        t_votes();
        t_interlace();
        t_hd_tri();
        t_hd_bilevel();
        t_tri_count();
        t_ed_tri();
        t_loss();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule